// File: doc/BRIEF.md
# PWM Current-Limit and Fault Override Stage

This stage sits between a PWM generator and the output drivers. It picks one current-limit source and one fault source from a vector of ten external inputs, each with its own 4-bit select code. When the selected current-limit input asserts, the pulse in progress is cut short and the outputs take programmed override levels. Those levels hold until the next PWM cycle start, so the switching period stays fixed. A fault forces a second set of programmed levels. It can be cleared by the next cycle start, or it can stay latched until software clears it.

The stage also keeps three interrupt flags: trigger, current-limit and fault. It drives one request line that is the OR of the three flags. A status bit shows either the current-limit flag or the live level of the selected current-limit input, chosen by the current-limit interrupt enable. Pin synchronization and dead time are handled outside this stage.

Top module: `pwm_limit_override`

## Requirements
- R1: Select codes 0 to 9 choose `src_pins[code]`. Codes 10 to 15 choose no input, and that source reads as inactive.
- R2: While `cl_en` is 1 and the selected current-limit input is 1, `{pwm_hi_out,pwm_lo_out}` equals `{cl_ovr_hi,cl_ovr_lo}` in the same cycle, without waiting for a clock edge.
- R3: Once the current-limit input has been sampled high at a clock edge, the current-limit override holds after the input falls. It is released only at the clock edge where `cyc_start` is 1.
- R4: With `flt_latch_mode`=1, a fault override holds across cycle starts until a `flt_clr` pulse is sampled while the selected fault input is 0. A `flt_clr` pulse sampled while the input is 1 has no effect.
- R5: With `flt_latch_mode`=0, a captured fault is released at the clock edge where `cyc_start` is 1, provided the fault input is 0 at that edge.
- R6: Override priority runs from fault override, to current-limit override, to the raw PWM inputs.
- R7: With `cl_en`=0 and `flt_en`=0, `pwm_hi_in` and `pwm_lo_in` pass straight through to the outputs, whatever the pin levels.
- R8: With `cl_irq_en`=0, `cl_status` equals the level of the selected current-limit input. With `cl_irq_en`=1, it equals the current-limit interrupt flag.
- R9: A flag sets on a sampled rising edge of its selected input, or on `trig_evt` for the trigger flag, when its interrupt enable is 1. An `irq_clr` pulse clears all flags. `irq` is the OR of the three flags. A level that stays high does not set a flag again.
- R10: After reset, all flags are 0, `irq` is 0, no override is captured, and the outputs follow the raw PWM inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwm_hi_in | input | 1 | Raw high-side PWM |
| pwm_lo_in | input | 1 | Raw low-side PWM |
| cyc_start | input | 1 | PWM cycle start strobe |
| src_pins | input | 10 | External limit/fault inputs (already synchronized) |
| cl_sel | input | 4 | Current-limit source select |
| flt_sel | input | 4 | Fault source select |
| cl_en | input | 1 | Current-limit override enable |
| flt_en | input | 1 | Fault override enable |
| cl_ovr_hi | input | 1 | High-side level during current limit |
| cl_ovr_lo | input | 1 | Low-side level during current limit |
| flt_ovr_hi | input | 1 | High-side level during fault |
| flt_ovr_lo | input | 1 | Low-side level during fault |
| flt_latch_mode | input | 1 | 1: fault latched until cleared; 0: fault cleared each cycle |
| flt_clr | input | 1 | Software fault clear pulse |
| trig_evt | input | 1 | Trigger event pulse |
| cl_irq_en | input | 1 | Current-limit interrupt enable |
| flt_irq_en | input | 1 | Fault interrupt enable |
| trig_irq_en | input | 1 | Trigger interrupt enable |
| irq_clr | input | 1 | Clears all interrupt flags |
| pwm_hi_out | output | 1 | Final high-side PWM |
| pwm_lo_out | output | 1 | Final low-side PWM |
| cl_status | output | 1 | Current-limit flag or live input level |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a latched fault clear that arrives while the fault input is still high. It must be ignored, and the override must then survive a cycle start and release only on a later clear. The stimulus holds the fault pin high across one `flt_clr` pulse, then drops the pin, sends a `cyc_start`, and only then issues a second clear. The current-limit hold is reached the same way: the pin is lowered before any cycle start, so the outputs reveal the captured state alone.

// File: rtl/pwm_limit_override.sv
module pwm_limit_override #(
  parameter int N_SRC = 10,
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwm_hi_in,
  input  logic             pwm_lo_in,
  input  logic             cyc_start,
  input  logic [N_SRC-1:0] src_pins,
  input  logic [SEL_W-1:0] cl_sel,
  input  logic [SEL_W-1:0] flt_sel,
  input  logic             cl_en,
  input  logic             flt_en,
  input  logic             cl_ovr_hi,
  input  logic             cl_ovr_lo,
  input  logic             flt_ovr_hi,
  input  logic             flt_ovr_lo,
  input  logic             flt_latch_mode,
  input  logic             flt_clr,
  input  logic             trig_evt,
  input  logic             cl_irq_en,
  input  logic             flt_irq_en,
  input  logic             trig_irq_en,
  input  logic             irq_clr,
  output logic             pwm_hi_out,
  output logic             pwm_lo_out,
  output logic             cl_status,
  output logic             irq
);

  logic cl_in, flt_in;
  logic cl_hold_q, flt_hold_q;
  logic cl_prev_q, flt_prev_q;
  logic cl_flag_q, flt_flag_q, trig_flag_q;
  logic cl_ovr, flt_ovr;

  assign cl_in  = (int'(cl_sel)  < N_SRC) ? src_pins[cl_sel]  : 1'b0;
  assign flt_in = (int'(flt_sel) < N_SRC) ? src_pins[flt_sel] : 1'b0;

  assign cl_ovr  = cl_en  & (cl_in  | cl_hold_q);
  assign flt_ovr = flt_en & (flt_in | flt_hold_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cl_hold_q  <= 1'b0;
      flt_hold_q <= 1'b0;
    end else begin
      if (cyc_start)              cl_hold_q <= 1'b0;
      else if (cl_en && cl_in)    cl_hold_q <= 1'b1;

      if (flt_en && flt_in)       flt_hold_q <= 1'b1;
      else if (flt_latch_mode) begin
        if (flt_clr)              flt_hold_q <= 1'b0;
      end else if (cyc_start)     flt_hold_q <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cl_prev_q   <= 1'b0;
      flt_prev_q  <= 1'b0;
      cl_flag_q   <= 1'b0;
      flt_flag_q  <= 1'b0;
      trig_flag_q <= 1'b0;
    end else begin
      cl_prev_q  <= cl_in;
      flt_prev_q <= flt_in;
      if (cl_irq_en && cl_in && !cl_prev_q)     cl_flag_q <= 1'b1;
      else if (irq_clr)                         cl_flag_q <= 1'b0;
      if (flt_irq_en && flt_in && !flt_prev_q)  flt_flag_q <= 1'b1;
      else if (irq_clr)                         flt_flag_q <= 1'b0;
      if (trig_irq_en && trig_evt)              trig_flag_q <= 1'b1;
      else if (irq_clr)                         trig_flag_q <= 1'b0;
    end
  end

  assign pwm_hi_out = flt_ovr ? flt_ovr_hi : (cl_ovr ? cl_ovr_hi : pwm_hi_in);
  assign pwm_lo_out = flt_ovr ? flt_ovr_lo : (cl_ovr ? cl_ovr_lo : pwm_lo_in);
  assign cl_status  = cl_irq_en ? cl_flag_q : cl_in;
  assign irq        = cl_flag_q | flt_flag_q | trig_flag_q;

endmodule

module pwm_limit_override_chk (
  input logic clk,
  input logic rst_n,
  input logic pwm_hi_in,
  input logic pwm_lo_in,
  input logic cyc_start,
  input logic cl_en,
  input logic flt_en,
  input logic cl_ovr_hi,
  input logic cl_ovr_lo,
  input logic flt_ovr_hi,
  input logic flt_ovr_lo,
  input logic flt_latch_mode,
  input logic flt_clr,
  input logic trig_evt,
  input logic trig_irq_en,
  input logic cl_irq_en,
  input logic pwm_hi_out,
  input logic pwm_lo_out,
  input logic cl_status,
  input logic irq,
  input logic cl_in,
  input logic flt_in,
  input logic flt_ovr,
  input logic flt_hold_q
);

  p_cl_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cl_en && cl_in && !cyc_start) |=>
      (!cl_en || flt_ovr || (pwm_hi_out == cl_ovr_hi && pwm_lo_out == cl_ovr_lo)));

  p_flt_latch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_hold_q && flt_en && flt_latch_mode && !flt_clr) |=>
      (!flt_en || (pwm_hi_out == flt_ovr_hi && pwm_lo_out == flt_ovr_lo)));

  p_flt_cycle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!flt_latch_mode && cyc_start && !(flt_en && flt_in)) |=> !flt_hold_q);

  p_passthru_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cl_en && !flt_en) |-> (pwm_hi_out == pwm_hi_in && pwm_lo_out == pwm_lo_in));

  p_raw_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cl_irq_en |-> (cl_status == cl_in));

  p_trig_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_evt && trig_irq_en) |=> irq);

endmodule

bind pwm_limit_override pwm_limit_override_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pwm_hi_in(pwm_hi_in), .pwm_lo_in(pwm_lo_in),
  .cyc_start(cyc_start), .cl_en(cl_en), .flt_en(flt_en),
  .cl_ovr_hi(cl_ovr_hi), .cl_ovr_lo(cl_ovr_lo),
  .flt_ovr_hi(flt_ovr_hi), .flt_ovr_lo(flt_ovr_lo),
  .flt_latch_mode(flt_latch_mode), .flt_clr(flt_clr), .trig_evt(trig_evt),
  .trig_irq_en(trig_irq_en), .cl_irq_en(cl_irq_en),
  .pwm_hi_out(pwm_hi_out), .pwm_lo_out(pwm_lo_out), .cl_status(cl_status),
  .irq(irq), .cl_in(cl_in), .flt_in(flt_in), .flt_ovr(flt_ovr),
  .flt_hold_q(flt_hold_q)
);

// File: tb/pwm_limit_override_tb_top.sv
`timescale 1ns/1ps
module pwm_limit_override_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwm_hi_in = 1'b1, pwm_lo_in = 1'b0, cyc_start = 1'b0;
  logic [9:0] src_pins = '0;
  logic [3:0] cl_sel = '0, flt_sel = '0;
  logic cl_en = 0, flt_en = 0;
  logic cl_ovr_hi = 0, cl_ovr_lo = 0, flt_ovr_hi = 0, flt_ovr_lo = 1;
  logic flt_latch_mode = 0, flt_clr = 0, trig_evt = 0;
  logic cl_irq_en = 0, flt_irq_en = 0, trig_irq_en = 0, irq_clr = 0;
  logic pwm_hi_out, pwm_lo_out, cl_status, irq;
  int n_run = 0, n_fail = 0;

  always #2 clk = ~clk;

  pwm_limit_override dut_i (.*);

  // output pair codes: PWM raw = 2'b10, current limit = 2'b00, fault = 2'b01
  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  function automatic logic [1:0] outs();
    return {pwm_hi_out, pwm_lo_out};
  endfunction

  task automatic t_reset();
    chk("R10 outputs", outs(), 2'b10);
    chk("R10 irq", {1'b0, irq}, 2'b00);
  endtask

  task automatic t_select();
    cl_en = 1;
    for (int c = 0; c < 16; c++) begin
      cl_sel = 4'(c);
      src_pins = (c < 10) ? (10'd1 << c) : '1;
      #1 chk($sformatf("R1 code %0d", c), outs(), (c < 10) ? 2'b00 : 2'b10);
      src_pins = '0;
      tick();
    end
    cl_en = 0;
  endtask

  task automatic t_cl_trunc();
    cl_en = 1; cl_sel = 4'd2;
    src_pins[2] = 1;
    #1 chk("R2 immediate", outs(), 2'b00);
    tick();
    src_pins[2] = 0;
    #1 chk("R3 hold after drop", outs(), 2'b00);
    tick();
    chk("R3 hold next cycle", outs(), 2'b00);
    cyc_start = 1;
    #1 chk("R3 hold until edge", outs(), 2'b00);
    tick();
    cyc_start = 0;
    #1 chk("R3 released", outs(), 2'b10);
    cl_en = 0;
  endtask

  task automatic t_fault_latch();
    flt_en = 1; flt_sel = 4'd5; flt_latch_mode = 1;
    src_pins[5] = 1;
    #1 chk("R4 fault on", outs(), 2'b01);
    tick();
    flt_clr = 1; tick(); flt_clr = 0;
    src_pins[5] = 0;
    #1 chk("R4 clear ignored while high", outs(), 2'b01);
    cyc_start = 1; tick(); cyc_start = 0;
    chk("R4 survives cycle start", outs(), 2'b01);
    flt_clr = 1; tick(); flt_clr = 0;
    chk("R4 cleared", outs(), 2'b10);
    flt_en = 0; flt_latch_mode = 0;
  endtask

  task automatic t_fault_cycle();
    flt_en = 1; flt_sel = 4'd5; flt_latch_mode = 0;
    src_pins[5] = 1; tick(); src_pins[5] = 0;
    #1 chk("R5 captured", outs(), 2'b01);
    tick();
    chk("R5 held before start", outs(), 2'b01);
    cyc_start = 1; tick(); cyc_start = 0;
    chk("R5 released at start", outs(), 2'b10);
    flt_en = 0;
  endtask

  task automatic t_priority();
    cl_en = 1; flt_en = 1; cl_sel = 4'd1; flt_sel = 4'd3;
    src_pins = 10'b00_0000_1010;
    #1 chk("R6 fault over limit", outs(), 2'b01);
    src_pins = 10'b00_0000_0010;
    #1 chk("R6 limit over pwm", outs(), 2'b00);
    src_pins = '0;
    #1 chk("R6 pwm", outs(), 2'b10);
    cl_en = 0; flt_en = 0;
  endtask

  task automatic t_enables();
    cl_sel = 4'd0; flt_sel = 4'd0;
    src_pins = '1;
    #1 chk("R7 pass hi", outs(), 2'b10);
    pwm_hi_in = 0; pwm_lo_in = 1;
    #1 chk("R7 pass lo", outs(), 2'b01);
    pwm_hi_in = 1; pwm_lo_in = 0; src_pins = '0;
    tick();
  endtask

  task automatic t_status_irq();
    cl_sel = 4'd4;
    src_pins[4] = 1;
    #1 chk("R8 raw high", {1'b0, cl_status}, 2'b01);
    src_pins[4] = 0;
    #1 chk("R8 raw low", {1'b0, cl_status}, 2'b00);
    cl_irq_en = 1; tick();
    src_pins[4] = 1; tick();
    chk("R9 cl flag irq", {cl_status, irq}, 2'b11);
    src_pins[4] = 0; tick();
    chk("R8 flag shown", {cl_status, irq}, 2'b11);
    irq_clr = 1; tick(); irq_clr = 0;
    chk("R9 cleared", {cl_status, irq}, 2'b00);
    trig_evt = 1; tick(); trig_evt = 0;
    chk("R9 trig masked", {1'b0, irq}, 2'b00);
    trig_irq_en = 1; trig_evt = 1; tick(); trig_evt = 0;
    chk("R9 trig irq", {1'b0, irq}, 2'b01);
    irq_clr = 1; tick(); irq_clr = 0;
    chk("R9 trig cleared", {1'b0, irq}, 2'b00);
    flt_irq_en = 1; flt_sel = 4'd6;
    src_pins[6] = 1; tick();
    chk("R9 fault irq", {1'b0, irq}, 2'b01);
    irq_clr = 1; tick(); irq_clr = 0;
    tick();
    chk("R9 level does not re-set", {1'b0, irq}, 2'b00);
    src_pins[6] = 0;
  endtask

  initial begin
    #(4 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #1 t_reset();
    #6 rst_n = 1;
    tick();
    t_reset();
    t_select();
    t_cl_trunc();
    t_fault_latch();
    t_fault_cycle();
    t_priority();
    t_enables();
    t_status_irq();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule